// File: doc/BRIEF.md
# Remappable Chip-Select Address Decoder

This block turns a CPU bus address into one-hot select lines for the boot ROM, main RAM, the on-chip configuration registers, the on-chip SRAM and five fixed peripheral windows. The ROM window is not fixed. It is set by two registers that the CPU writes over the same bus. The first is a base register and the second is an option register that sets the window size and whether the window is read-only.

Out of reset the ROM answers at address zero, so the processor can fetch its vectors there. Boot code copies a short stub into on-chip SRAM, runs from that stub, and writes a new ROM base. The ROM then answers in high memory and RAM becomes visible at zero. The SRAM select does not depend on the ROM registers, so the stub keeps running while the remap happens. A write to a read-only ROM window is blocked, and an access that falls in no region is flagged.

Top module: `cs_decoder`

## Requirements
- R1: After reset the ROM base is 0x0000 and the window is 256 KB and read-only. A read anywhere in 0x00000000–0x0003FFFF selects ROM (sel bit 2). A read in 0x00040000–0x0007FFFF selects RAM (sel bit 3).
- R2: A write strobe at address 0x00FC0040 loads wdata_i into the ROM base on the clock edge. From the next cycle the ROM window starts at {base,16'h0000}. With base 0xFFF8 and the reset option, 0xFFF80000–0xFFFBFFFF selects ROM and 0xFFFC0000 is unmapped.
- R3: Once the ROM has moved off zero, every address in 0x00000000–0x0007FFFF selects RAM.
- R4: A write strobe at address 0x00FC0044 loads the option register. Bits [13:12] are a size code n, and the window is 32 KB << n. Bit 5 set makes the window read-only. The reset value is 0x7830.
- R5: A write that hits a read-only ROM window asserts no select and leaves unmapped_o low. It raises wp_err_o in the next cycle only.
- R6: When option bit 5 is clear, a write in the ROM window selects ROM and wp_err_o stays low.
- R7: The fixed windows select as follows: DSP 0x300000–0x30001F (bit 4), front panel 0x400000–0x400003 (bit 5), disk controller 0x408000–0x408007 (bit 6), SCSI 0x410000–0x41000F (bit 7), sample RAM 0x500000–0x5FFFFF (bit 8). The address one past each window's end is unmapped.
- R8: A strobed access that matches no region raises unmapped_o and asserts no select.
- R9: 0xFC0000–0xFC07FF selects the configuration registers (bit 0) and 0xFC0800–0xFC0FFF selects SRAM (bit 1). Both take priority over the ROM window even when the ROM base is placed over them. ROM takes priority over RAM and over the peripheral windows.
- R10: With as_i low, sel_o is all zero and unmapped_o is low.
- R11: Asserting rst_ni low at any time returns both registers to their boot values. The ROM is then mapped at zero again and is read-only.
- R12: At most one bit of sel_o is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| as_i | input | 1 | Address strobe, access valid |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 16 | Write data for the chip-select registers |
| sel_o | output | 9 | One-hot select, bit order cfg, sram, rom, ram, dsp, panel, disk, scsi, sample |
| wp_err_o | output | 1 | Write-protect error, one cycle after a blocked write |
| unmapped_o | output | 1 | Strobed access matched no region |

## Verification
The assertions rely on as_i, we_i and addr_i being stable and defined through each clock edge, because the protected-write check compares the registered error pulse with the previous cycle's decode. The stimulus changes inputs only on the falling edge. It keeps the strobe low between scenarios, except where a blocked write has to be held through a rising edge to produce the pulse. Register writes are held for exactly one rising edge, so each base or option value takes effect at a known cycle.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 16;
  localparam int NUM_SEL = 9;
  localparam int NUM_FIX = 8;

  typedef enum int {
    SEL_CFG = 0, SEL_SRAM = 1, SEL_ROM = 2, SEL_RAM = 3, SEL_DSP = 4,
    SEL_PANEL = 5, SEL_DISK = 6, SEL_SCSI = 7, SEL_SMP = 8
  } sel_e;

  // fixed window index 0..7 maps to sel bits cfg, sram, ram, dsp .. smp
  localparam int FIX_CFG = 0, FIX_SRAM = 1, FIX_RAM = 2;

  localparam logic [ADDR_W-1:0] FIX_BASE [NUM_FIX] = '{
    32'h00FC_0000, 32'h00FC_0800, 32'h0000_0000, 32'h0030_0000,
    32'h0040_0000, 32'h0040_8000, 32'h0041_0000, 32'h0050_0000
  };
  localparam logic [ADDR_W-1:0] FIX_SIZE [NUM_FIX] = '{
    32'h0000_0800, 32'h0000_0800, 32'h0008_0000, 32'h0000_0020,
    32'h0000_0004, 32'h0000_0008, 32'h0000_0010, 32'h0010_0000
  };

  localparam logic [ADDR_W-1:0] REG_BASE_ADDR = 32'h00FC_0040;
  localparam logic [ADDR_W-1:0] REG_OPT_ADDR  = 32'h00FC_0044;

  localparam logic [DATA_W-1:0] BOOT_BASE = 16'h0000;
  localparam logic [DATA_W-1:0] BOOT_OPT  = 16'h7830;

  localparam int SZ_W      = 2;
  localparam int SZ_LSB    = 12;
  localparam int RO_BIT    = 5;
  localparam int MIN_WIN_W = 15;
endpackage

// File: rtl/cs_reg_bank.sv
module cs_reg_bank
  import cs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] base_o,
  output logic [SZ_W-1:0]   size_o,
  output logic              ro_o
);
  logic hit_base, hit_opt;

  assign hit_base = wr_i && (addr_i == REG_BASE_ADDR);
  assign hit_opt  = wr_i && (addr_i == REG_OPT_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= BOOT_BASE;
      size_o <= BOOT_OPT[SZ_LSB +: SZ_W];
      ro_o   <= BOOT_OPT[RO_BIT];
    end else begin
      if (hit_base) base_o <= wdata_i;
      if (hit_opt) begin
        size_o <= wdata_i[SZ_LSB +: SZ_W];
        ro_o   <= wdata_i[RO_BIT];
      end
    end
  end
endmodule

// File: rtl/cs_rom_window.sv
module cs_rom_window
  import cs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [SZ_W-1:0]   size_i,
  output logic              hit_o
);
  localparam int SHIFT = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] base_addr, lo_mask;

  assign base_addr = {base_i, {SHIFT{1'b0}}};
  // window of 2^(MIN_WIN_W + size) bytes; low bits of base under it ignored
  assign lo_mask   = (ADDR_W'(1) << (MIN_WIN_W + int'(size_i))) - ADDR_W'(1);
  assign hit_o     = ((addr_i ^ base_addr) & ~lo_mask) == '0;
endmodule

// File: rtl/cs_fixed_decode.sv
module cs_fixed_decode
  import cs_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_FIX-1:0] hit_o
);
  for (genvar i = 0; i < NUM_FIX; i++) begin : g_win
    assign hit_o[i] = ((addr_i ^ FIX_BASE[i]) & ~(FIX_SIZE[i] - 1)) == '0;
  end
endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
  import cs_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               as_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [NUM_SEL-1:0] sel_o,
  output logic               wp_err_o,
  output logic               unmapped_o
);
  logic [DATA_W-1:0]  rom_base;
  logic [SZ_W-1:0]    rom_size;
  logic               rom_ro;
  logic               rom_hit;
  logic [NUM_FIX-1:0] fix_hit;
  logic               int_hit, rom_eff, ram_eff, wp_hit;
  logic [NUM_SEL-1:0] sel_raw;

  cs_reg_bank u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (as_i && we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .base_o  (rom_base),
    .size_o  (rom_size),
    .ro_o    (rom_ro)
  );

  cs_rom_window u_rom (
    .addr_i (addr_i),
    .base_i (rom_base),
    .size_i (rom_size),
    .hit_o  (rom_hit)
  );

  cs_fixed_decode u_fix (
    .addr_i (addr_i),
    .hit_o  (fix_hit)
  );

  // priority: internal > rom > ram/peripherals
  assign int_hit = fix_hit[FIX_CFG] | fix_hit[FIX_SRAM];
  assign rom_eff = rom_hit & ~int_hit;
  assign ram_eff = fix_hit[FIX_RAM] & ~int_hit & ~rom_hit;
  assign wp_hit  = as_i & we_i & rom_eff & rom_ro;

  always_comb begin
    sel_raw = '0;
    sel_raw[SEL_CFG]  = fix_hit[FIX_CFG];
    sel_raw[SEL_SRAM] = fix_hit[FIX_SRAM];
    sel_raw[SEL_ROM]  = rom_eff & ~wp_hit;
    sel_raw[SEL_RAM]  = ram_eff;
    for (int i = SEL_DSP; i < NUM_SEL; i++)
      sel_raw[i] = fix_hit[i - 1] & ~rom_hit;
  end

  assign sel_o      = as_i ? sel_raw : '0;
  assign unmapped_o = as_i & ~(|fix_hit) & ~rom_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wp_err_o <= 1'b0;
    else         wp_err_o <= wp_hit;
  end
endmodule

// File: rtl/cs_decoder_chk.sv
module cs_decoder_chk
  import cs_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               as_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [NUM_SEL-1:0] sel_o,
  input logic               wp_err_o,
  input logic               unmapped_o
);
  logic blocked;
  assign blocked = as_i && we_i && (sel_o == '0) && !unmapped_o;

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_i |-> (sel_o == '0) && !unmapped_o); // R10
  AST_UNMAPPED_NO_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_o |-> (sel_o == '0)); // R8
  AST_WP_AFTER_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked |=> wp_err_o); // R5
  AST_WP_ONLY_AFTER_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_err_o |-> $past(blocked)); // R5
  AST_SRAM_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_i && (addr_i & ~32'h7FF) == 32'h00FC_0800) |-> sel_o[SEL_SRAM]); // R9
  AST_CFG_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_i && (addr_i & ~32'h7FF) == 32'h00FC_0000) |-> sel_o[SEL_CFG]); // R9
endmodule

bind cs_decoder cs_decoder_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .as_i       (as_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .sel_o      (sel_o),
  .wp_err_o   (wp_err_o),
  .unmapped_o (unmapped_o)
);

// File: tb/cs_decoder_bench.sv
`timescale 1ns/1ps
module cs_decoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        as_i = 1'b0, we_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [8:0]  sel_o;
  logic        wp_err_o, unmapped_o;

  int n_vec = 0, n_err = 0;

  localparam logic [8:0] S_NONE = 9'h000, S_CFG = 9'h001, S_SRAM = 9'h002,
    S_ROM = 9'h004, S_RAM = 9'h008, S_DSP = 9'h010, S_PNL = 9'h020,
    S_DSK = 9'h040, S_SCSI = 9'h080, S_SMP = 9'h100;

  always #2 clk_i = ~clk_i;

  cs_decoder u_cs_decoder (.*);

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // combinational probe, strobe dropped before the next rising edge
  task automatic probe(string req, logic [31:0] a, logic w, logic [8:0] es, logic eu);
    @(negedge clk_i);
    as_i = 1'b1; we_i = w; addr_i = a;
    #1;
    cmp(req, $sformatf("sel @%h", a), 32'(sel_o), 32'(es));
    cmp(req, $sformatf("unmapped @%h", a), 32'(unmapped_o), 32'(eu));
    if ($countones(sel_o) > 1) cmp("R12", "onehot", 32'(sel_o), 32'(es));
    as_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic wr_reg(logic [31:0] a, logic [15:0] d);
    @(negedge clk_i);
    as_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    as_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic t_reset_idle();
    rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    #1;
    cmp("R10", "sel idle", 32'(sel_o), 0);
    cmp("R10", "unmapped idle", 32'(unmapped_o), 0);
    cmp("R11", "wp in reset", 32'(wp_err_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    addr_i = 32'h0000_0000; #1;
    cmp("R10", "sel strobe low", 32'(sel_o), 0);
  endtask

  task automatic t_boot_map();
    probe("R1", 32'h0000_0000, 1'b0, S_ROM, 1'b0);
    probe("R1", 32'h0003_FFFE, 1'b0, S_ROM, 1'b0);
    probe("R1", 32'h0004_0000, 1'b0, S_RAM, 1'b0);
    probe("R1", 32'h0007_FFFF, 1'b0, S_RAM, 1'b0);
    probe("R1", 32'hFFF8_0000, 1'b0, S_NONE, 1'b1);
  endtask

  task automatic t_fixed();
    probe("R7", 32'h0030_0000, 1'b0, S_DSP, 1'b0);
    probe("R7", 32'h0030_001F, 1'b0, S_DSP, 1'b0);
    probe("R7", 32'h0030_0020, 1'b0, S_NONE, 1'b1);
    probe("R7", 32'h0040_0003, 1'b1, S_PNL, 1'b0);
    probe("R7", 32'h0040_0004, 1'b0, S_NONE, 1'b1);
    probe("R7", 32'h0040_8007, 1'b0, S_DSK, 1'b0);
    probe("R7", 32'h0040_8008, 1'b0, S_NONE, 1'b1);
    probe("R7", 32'h0041_000F, 1'b0, S_SCSI, 1'b0);
    probe("R7", 32'h0041_0010, 1'b0, S_NONE, 1'b1);
    probe("R7", 32'h0050_0000, 1'b0, S_SMP, 1'b0);
    probe("R7", 32'h005F_FFFF, 1'b1, S_SMP, 1'b0);
    probe("R7", 32'h0060_0000, 1'b0, S_NONE, 1'b1);
  endtask

  task automatic t_unmapped();
    probe("R8", 32'h0008_0000, 1'b0, S_NONE, 1'b1);
    probe("R8", 32'h00FC_1000, 1'b1, S_NONE, 1'b1);
    probe("R8", 32'h8000_0000, 1'b0, S_NONE, 1'b1);
  endtask

  task automatic t_internal();
    probe("R9", 32'h00FC_0000, 1'b0, S_CFG, 1'b0);
    probe("R9", 32'h00FC_07FF, 1'b0, S_CFG, 1'b0);
    probe("R9", 32'h00FC_0800, 1'b0, S_SRAM, 1'b0);
    probe("R9", 32'h00FC_0FFF, 1'b1, S_SRAM, 1'b0);
  endtask

  task automatic t_relocate();
    wr_reg(32'h00FC_0040, 16'hFFF8);
    probe("R2", 32'hFFF8_0000, 1'b0, S_ROM, 1'b0);
    probe("R2", 32'hFFFB_FFFF, 1'b0, S_ROM, 1'b0);
    probe("R2", 32'hFFFC_0000, 1'b0, S_NONE, 1'b1);
    probe("R3", 32'h0000_0000, 1'b0, S_RAM, 1'b0);
    probe("R3", 32'h0003_FFFC, 1'b1, S_RAM, 1'b0);
    probe("R3", 32'h0007_FFFF, 1'b0, S_RAM, 1'b0);
    probe("R9", 32'h00FC_0800, 1'b0, S_SRAM, 1'b0);
  endtask

  task automatic t_wp();
    @(negedge clk_i);
    as_i = 1'b1; we_i = 1'b1; addr_i = 32'hFFF8_0100;
    #1;
    cmp("R5", "sel on blocked write", 32'(sel_o), 0);
    cmp("R5", "unmapped on blocked write", 32'(unmapped_o), 0);
    cmp("R5", "wp before edge", 32'(wp_err_o), 0);
    @(posedge clk_i); #1;
    as_i = 1'b0; we_i = 1'b0;
    cmp("R5", "wp after edge", 32'(wp_err_o), 1);
    @(posedge clk_i); #1;
    cmp("R5", "wp second cycle", 32'(wp_err_o), 0);
  endtask

  task automatic t_option();
    wr_reg(32'h00FC_0044, 16'h6810);
    probe("R4", 32'hFFF9_FFFC, 1'b0, S_ROM, 1'b0);
    probe("R4", 32'hFFFA_0000, 1'b0, S_NONE, 1'b1);
    @(negedge clk_i);
    as_i = 1'b1; we_i = 1'b1; addr_i = 32'hFFF8_0000;
    #1;
    cmp("R6", "sel rw write", 32'(sel_o), 32'(S_ROM));
    @(posedge clk_i); #1;
    as_i = 1'b0; we_i = 1'b0;
    cmp("R6", "no wp on rw write", 32'(wp_err_o), 0);
    wr_reg(32'h00FC_0044, 16'h4810);
    probe("R4", 32'hFFF8_7FFE, 1'b0, S_ROM, 1'b0);
    probe("R4", 32'hFFF8_8000, 1'b0, S_NONE, 1'b1);
    wr_reg(32'h00FC_0044, 16'h7830);
    probe("R4", 32'hFFFB_FFFF, 1'b0, S_ROM, 1'b0);
  endtask

  task automatic t_overlap();
    wr_reg(32'h00FC_0040, 16'h00FC);
    probe("R9", 32'h00FC_0000, 1'b0, S_CFG, 1'b0);
    probe("R9", 32'h00FC_0800, 1'b0, S_SRAM, 1'b0);
    probe("R9", 32'h00FD_0000, 1'b0, S_ROM, 1'b0);
    wr_reg(32'h00FC_0040, 16'h0030);
    probe("R9", 32'h0030_0000, 1'b0, S_ROM, 1'b0);
    wr_reg(32'h00FC_0040, 16'hFFF8);
    probe("R9", 32'hFFF8_0000, 1'b0, S_ROM, 1'b0);
  endtask

  task automatic t_reset_restore();
    wr_reg(32'h00FC_0044, 16'h6810);
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    @(negedge clk_i); rst_ni = 1'b1;
    probe("R11", 32'h0000_0000, 1'b0, S_ROM, 1'b0);
    probe("R11", 32'h0003_FFFF, 1'b0, S_ROM, 1'b0);
    probe("R11", 32'hFFF8_0000, 1'b0, S_NONE, 1'b1);
    @(negedge clk_i);
    as_i = 1'b1; we_i = 1'b1; addr_i = 32'h0000_0010;
    #1;
    cmp("R11", "write blocked after reset", 32'(sel_o), 0);
    @(posedge clk_i); #1;
    as_i = 1'b0; we_i = 1'b0;
    cmp("R11", "wp after reset", 32'(wp_err_o), 1);
  endtask

  initial begin
    #(200000 * 4);
    n_vec++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    t_reset_idle();
    t_boot_map();
    t_fixed();
    t_unmapped();
    t_internal();
    t_relocate();
    t_wp();
    t_option();
    t_overlap();
    t_reset_restore();
    repeat (2) @(posedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule